// File: doc/BRIEF.md
# Reset Cause Detector with Status Register

This block sits beside the CPU bus. It watches the bus accesses, the STOP-instruction decode, a few configuration inputs and the low-voltage detector, and it decides when the chip must be reset. A STOP executed while stopping is disabled counts as an illegal opcode. An opcode fetch from an address that the decoder reports as unmapped counts as an illegal address. A data read from an unmapped address is harmless. Two data reads of the reset vector that both return an erased value force a reset, and the chip then comes back up in monitor mode. A low-voltage event resets the chip only when the configuration allows it, and that reset is held for as long as the supply stays low.

Each cause sets its own bit in a status register. The bit stays set until software reads the register or a power-on reset occurs. The address decoder, the CPU and the analog comparator are outside the block. Power-on reset is the block's synchronous reset input.

Top module: `rst_cause_unit`

## Requirements
- R1: A STOP decode (`stop_exec_i`) while `cfg_stop_en_i` is 0 sets status bit 1 (illegal opcode) and raises `rst_req_o` in the following cycle.
- R2: A STOP decode while `cfg_stop_en_i` is 1 changes neither the status nor `rst_req_o`.
- R3: An opcode fetch (`bus_rd_i` and `bus_opc_i`) with `bus_mapped_i` low sets status bit 2 (illegal address) and raises `rst_req_o` in the following cycle.
- R4: A data read (`bus_opc_i` low) from an unmapped address, and an opcode fetch from a mapped address, set no status bit and raise no reset.
- R5: A data read of `VEC_ADDR` returning all ones, followed later by a data read of `VEC_ADDR+1` returning all ones, sets status bit 3 (monitor entry) and raises `rst_req_o`. It also sets `mon_force_o`, which stays high until power-on reset. A read of `VEC_ADDR` that returns any other value disarms the check.
- R6: `lvd_trip_i` sets status bit 4 (low voltage) and raises `rst_req_o` only when `cfg_lvi_pwrdn_i` and `cfg_lvi_rstdis_i` are both 0. Otherwise it has no effect.
- R7: After a qualified low-voltage event, `rst_req_o` stays high while `lvd_low_i` is high. It falls one cycle after `lvd_low_i` goes low, provided the pulse timer has already expired.
- R8: Any other cause holds `rst_req_o` high for exactly `PULSE_LEN` cycles. A new cause during the pulse restarts the count.
- R9: Power-on reset (`rst`) leaves the status at 5'b00001 (bit 0 = POR only), with `mon_force_o` and `rst_req_o` low.
- R10: A status read (`stat_rd_i`) clears all status bits in the next cycle. A cause that arrives in the same cycle as the read is still recorded.
- R11: When several causes occur in one cycle, every matching status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_opc_i | input | 1 | The read is an opcode fetch |
| bus_addr_i | input | ADDR_W | Read address |
| bus_mapped_i | input | 1 | Address decoder reports the address as mapped |
| bus_data_i | input | DATA_W | Data returned by the read |
| stop_exec_i | input | 1 | STOP instruction decoded |
| cfg_stop_en_i | input | 1 | STOP is allowed |
| cfg_lvi_pwrdn_i | input | 1 | Low-voltage detector powered down |
| cfg_lvi_rstdis_i | input | 1 | Low-voltage reset disabled |
| lvd_trip_i | input | 1 | Supply fell to the falling trip point |
| lvd_low_i | input | 1 | Supply still below the rising trip point |
| stat_rd_i | input | 1 | Status register read (clear on read) |
| rst_req_o | output | 1 | Chip reset request |
| mon_force_o | output | 1 | Forced monitor mode after an erased vector |
| status_o | output | 5 | Cause bits: 0 POR, 1 illegal opcode, 2 illegal address, 3 monitor entry, 4 low voltage |

## Verification
The directed cases target the qualifications that are easy to get wrong. An unmapped data read must not reset the chip, and a design that ignored the fetch type would reset on it. A STOP executed while stopping is enabled must do nothing. A low-voltage trip with either configuration bit set must be ignored, and a design that tested only one bit would reset on the other. The directed cases also cover a vector whose first byte is not erased, which a design that forgot to disarm would treat as erased. Further cases check that a read and a cause in the same cycle keep the cause, and that the low-voltage reset outlasts the pulse timer and falls only when the supply recovers. Random traffic with a fixed seed is then compared cycle by cycle against a model of the requirements, which exposes lost bits when causes coincide and wrong pulse lengths when causes retrigger.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

    localparam int NUM_CAUSES = 5;

    // bit 0 POR, 1 illegal opcode, 2 illegal address, 3 monitor entry, 4 low voltage
    typedef struct packed {
        logic lvi;
        logic menr;
        logic ilad;
        logic ilop;
        logic por;
    } cause_t;

    function automatic cause_t cause_none();
        cause_t c;
        c = '0;
        return c;
    endfunction

    function automatic cause_t cause_por_only();
        cause_t c;
        c = '0;
        c.por = 1'b1;
        return c;
    endfunction

    // causes that start the pulse timer (low voltage included)
    function automatic logic cause_any(cause_t c);
        return c.ilop | c.ilad | c.menr | c.lvi;
    endfunction

    function automatic cause_t cause_merge(cause_t a, cause_t b);
        return cause_t'(a | b);
    endfunction

endpackage

// File: rtl/rst_cause_detect.sv
module rst_cause_detect
    import rst_cause_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] VEC_ADDR = '1 - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd_i,
    input  logic              bus_opc_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_mapped_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              stop_exec_i,
    input  logic              cfg_stop_en_i,
    input  logic              cfg_lvi_pwrdn_i,
    input  logic              cfg_lvi_rstdis_i,
    input  logic              lvd_trip_i,
    output cause_t            hits_o
);
    localparam logic [ADDR_W-1:0] VEC_HI = VEC_ADDR;
    localparam logic [ADDR_W-1:0] VEC_LO = VEC_ADDR + ADDR_W'(1);
    localparam logic [DATA_W-1:0] ERASED = '1;

    logic data_rd;
    logic data_erased;
    logic hi_erased_q;

    assign data_rd     = bus_rd_i & ~bus_opc_i;
    assign data_erased = (bus_data_i == ERASED);

    // remembers whether the last high vector byte read back erased
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_erased_q <= 1'b0;
        end else if (data_rd && bus_addr_i == VEC_HI) begin
            hi_erased_q <= data_erased;
        end
    end

    always_comb begin
        hits_o      = cause_none();
        hits_o.ilop = stop_exec_i & ~cfg_stop_en_i;
        hits_o.ilad = bus_rd_i & bus_opc_i & ~bus_mapped_i;
        hits_o.menr = data_rd & (bus_addr_i == VEC_LO) & data_erased & hi_erased_q;
        hits_o.lvi  = lvd_trip_i & ~cfg_lvi_pwrdn_i & ~cfg_lvi_rstdis_i;
    end

endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
    import rst_cause_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t hits_i,
    input  logic   clr_i,
    output cause_t stat_o,
    output logic   mon_o
);
    cause_t stat_q;
    cause_t base;
    logic   mon_q;

    assign base = clr_i ? cause_none() : stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= cause_por_only();
            mon_q  <= 1'b0;
        end else begin
            stat_q <= cause_merge(base, hits_i);
            mon_q  <= mon_q | hits_i.menr;
        end
    end

    assign stat_o = stat_q;
    assign mon_o  = mon_q;

endmodule

// File: rtl/rst_cause_timer.sv
module rst_cause_timer
    import rst_cause_pkg::*;
#(
    parameter int PULSE_LEN = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  cause_t hits_i,
    input  logic   lvd_low_i,
    output logic   req_o
);
    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

    logic [CW-1:0] cnt_q;
    logic          hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cause_any(hits_i)) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // low-voltage hold follows the supply comparator
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else if (hits_i.lvi) begin
            hold_q <= 1'b1;
        end else if (!lvd_low_i) begin
            hold_q <= 1'b0;
        end
    end

    assign req_o = (cnt_q != '0) | hold_q;

endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
    import rst_cause_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFE,
    parameter int PULSE_LEN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd_i,
    input  logic              bus_opc_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_mapped_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              stop_exec_i,
    input  logic              cfg_stop_en_i,
    input  logic              cfg_lvi_pwrdn_i,
    input  logic              cfg_lvi_rstdis_i,
    input  logic              lvd_trip_i,
    input  logic              lvd_low_i,
    input  logic              stat_rd_i,
    output logic              rst_req_o,
    output logic              mon_force_o,
    output logic [NUM_CAUSES-1:0] status_o
);
    cause_t hits;
    cause_t stat;

    rst_cause_detect #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .VEC_ADDR (VEC_ADDR)
    ) u_detect (
        .clk              (clk),
        .rst              (rst),
        .bus_rd_i         (bus_rd_i),
        .bus_opc_i        (bus_opc_i),
        .bus_addr_i       (bus_addr_i),
        .bus_mapped_i     (bus_mapped_i),
        .bus_data_i       (bus_data_i),
        .stop_exec_i      (stop_exec_i),
        .cfg_stop_en_i    (cfg_stop_en_i),
        .cfg_lvi_pwrdn_i  (cfg_lvi_pwrdn_i),
        .cfg_lvi_rstdis_i (cfg_lvi_rstdis_i),
        .lvd_trip_i       (lvd_trip_i),
        .hits_o           (hits)
    );

    rst_cause_status u_status (
        .clk    (clk),
        .rst    (rst),
        .hits_i (hits),
        .clr_i  (stat_rd_i),
        .stat_o (stat),
        .mon_o  (mon_force_o)
    );

    rst_cause_timer #(
        .PULSE_LEN (PULSE_LEN)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .hits_i    (hits),
        .lvd_low_i (lvd_low_i),
        .req_o     (rst_req_o)
    );

    assign status_o = stat;

endmodule

// File: rtl/rst_cause_sva.sv
module rst_cause_sva #(
    parameter int PULSE_LEN = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_rd_i,
    input logic       bus_opc_i,
    input logic       bus_mapped_i,
    input logic       stop_exec_i,
    input logic       cfg_stop_en_i,
    input logic       cfg_lvi_pwrdn_i,
    input logic       cfg_lvi_rstdis_i,
    input logic       lvd_trip_i,
    input logic       stat_rd_i,
    input logic       rst_req_o,
    input logic       mon_force_o,
    input logic [4:0] status_o
);
    AST_ILOP_RESET: assert property (@(posedge clk) disable iff (rst)
        (stop_exec_i && !cfg_stop_en_i) |=> (status_o[1] && rst_req_o)); // R1

    AST_ILAD_RESET: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && bus_opc_i && !bus_mapped_i) |=> (status_o[2] && rst_req_o)); // R3

    AST_DATA_NO_ILAD: assert property (@(posedge clk) disable iff (rst)
        (!(bus_rd_i && bus_opc_i) && !status_o[2]) |=> !status_o[2]); // R4

    AST_LVI_RESET: assert property (@(posedge clk) disable iff (rst)
        (lvd_trip_i && !cfg_lvi_pwrdn_i && !cfg_lvi_rstdis_i) |=> (status_o[4] && rst_req_o)); // R6

    AST_MON_STICKY: assert property (@(posedge clk) disable iff (rst)
        mon_force_o |=> mon_force_o); // R5

    AST_POR_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status_o == 5'b00001 && !mon_force_o && !rst_req_o)); // R9

    AST_READ_CLEARS_POR: assert property (@(posedge clk) disable iff (rst)
        stat_rd_i |=> !status_o[0]); // R10

    generate
        if (PULSE_LEN >= 2) begin : g_pulse
            AST_PULSE_MIN: assert property (@(posedge clk) disable iff (rst)
                $rose(rst_req_o) |=> rst_req_o); // R8
        end
    endgenerate

endmodule

bind rst_cause_unit rst_cause_sva #(.PULSE_LEN(PULSE_LEN)) u_sva (
    .clk              (clk),
    .rst              (rst),
    .bus_rd_i         (bus_rd_i),
    .bus_opc_i        (bus_opc_i),
    .bus_mapped_i     (bus_mapped_i),
    .stop_exec_i      (stop_exec_i),
    .cfg_stop_en_i    (cfg_stop_en_i),
    .cfg_lvi_pwrdn_i  (cfg_lvi_pwrdn_i),
    .cfg_lvi_rstdis_i (cfg_lvi_rstdis_i),
    .lvd_trip_i       (lvd_trip_i),
    .stat_rd_i        (stat_rd_i),
    .rst_req_o        (rst_req_o),
    .mon_force_o      (mon_force_o),
    .status_o         (status_o)
);

// File: tb/rst_cause_unit_tb.sv
`timescale 1ns/1ps
module rst_cause_unit_tb;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam logic [15:0] VA = 16'hFFFE;
    localparam int PL = 8;

    logic clk = 1'b0;
    logic rst, rd, opc, mapped, stp, sen, pd, rdis, trip, low, srd;
    logic [15:0] addr;
    logic [7:0] data;
    logic req, mon;
    logic [4:0] st;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state
    logic [4:0] m_st;
    int m_cnt;
    logic m_hold, m_mon, m_vh;

    always #4 clk = ~clk;

    rst_cause_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_ADDR(VA), .PULSE_LEN(PL)) u_dut (
        .clk(clk), .rst(rst), .bus_rd_i(rd), .bus_opc_i(opc), .bus_addr_i(addr),
        .bus_mapped_i(mapped), .bus_data_i(data), .stop_exec_i(stp),
        .cfg_stop_en_i(sen), .cfg_lvi_pwrdn_i(pd), .cfg_lvi_rstdis_i(rdis),
        .lvd_trip_i(trip), .lvd_low_i(low), .stat_rd_i(srd),
        .rst_req_o(req), .mon_force_o(mon), .status_o(st)
    );

    task automatic idle();
        rst = 0; rd = 0; opc = 0; mapped = 1; addr = 16'h0100; data = 8'h00;
        stp = 0; sen = 0; pd = 0; rdis = 0; trip = 0; low = 0; srd = 0;
    endtask

    function automatic void model_step();
        logic [4:0] nw;
        logic dr;
        if (rst) begin
            m_st = 5'b00001; m_cnt = 0; m_hold = 0; m_mon = 0; m_vh = 0;
        end else begin
            dr = rd & ~opc;
            nw = '0;
            nw[1] = stp & ~sen;
            nw[2] = rd & opc & ~mapped;
            nw[3] = dr & (addr == VA + 16'd1) & (data == 8'hFF) & m_vh;
            nw[4] = trip & ~pd & ~rdis;
            if (dr && addr == VA) m_vh = (data == 8'hFF);
            m_st = (srd ? 5'b0 : m_st) | nw;
            if (nw != 0) m_cnt = PL; else if (m_cnt > 0) m_cnt--;
            if (nw[4]) m_hold = 1; else if (!low) m_hold = 0;
            m_mon = m_mon | nw[3];
        end
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one clock: model follows the edge, outputs sampled 2 ns later
    task automatic step(string tag);
        @(posedge clk);
        model_step();
        #2;
        chk(tag, "status", st, m_st);
        chk(tag, "rst_req", req, (m_cnt != 0 || m_hold) ? 1 : 0);
        chk(tag, "mon", mon, m_mon);
        idle();
    endtask

    task automatic wait_quiet(string tag);
        for (int i = 0; i < PL + 2; i++) begin
            low = 0;
            step(tag);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_st = 0; m_cnt = 0; m_hold = 0; m_mon = 0; m_vh = 0;
        idle();
        rst = 1; step("R9 por");
        rst = 1; step("R9 por");
        chk("R9", "status after por", st, 5'b00001);
        chk("R9", "req after por", req, 0);
        srd = 1; step("R10 read clears");
        chk("R10", "status cleared", st, 0);

        // R1 / R2
        stp = 1; sen = 0; step("R1 stop disabled");
        chk("R1", "ilop bit", st[1], 1);
        chk("R1", "req", req, 1);
        wait_quiet("R8 pulse end");
        chk("R8", "pulse ended", req, 0);
        srd = 1; step("R10");
        stp = 1; sen = 1; step("R2 stop enabled");
        chk("R2", "no status", st, 0);
        chk("R2", "no req", req, 0);

        // R3 / R4
        rd = 1; opc = 0; mapped = 0; step("R4 data unmapped");
        chk("R4", "no ilad", st, 0);
        chk("R4", "no req", req, 0);
        rd = 1; opc = 1; mapped = 1; step("R4 opcode mapped");
        chk("R4", "no ilad mapped", st, 0);
        rd = 1; opc = 1; mapped = 0; step("R3 opcode unmapped");
        chk("R3", "ilad bit", st[2], 1);
        chk("R3", "req", req, 1);
        // R8 retrigger midway
        for (int i = 0; i < 3; i++) step("R8");
        stp = 1; step("R8 retrigger");
        for (int i = 0; i < PL - 1; i++) step("R8 retrigger hold");
        chk("R8", "still high at PL-1", req, 1);
        step("R8 drop");
        chk("R8", "low after PL", req, 0);
        srd = 1; step("R10");

        // R5 disarm then proper
        rd = 1; addr = VA; data = 8'h12; step("R5 hi not erased");
        rd = 1; addr = VA + 16'd1; data = 8'hFF; step("R5 lo only");
        chk("R5", "disarmed", st, 0);
        chk("R5", "mon low", mon, 0);
        rd = 1; addr = VA; data = 8'hFF; step("R5 hi erased");
        rd = 1; opc = 0; addr = 16'h0200; step("R5 unrelated");
        rd = 1; addr = VA + 16'd1; data = 8'hFF; srd = 1; step("R10 read with cause");
        chk("R5", "menr bit", st, 5'b01000);
        chk("R5", "mon high", mon, 1);
        chk("R10", "cause kept over read", st[3], 1);
        wait_quiet("R5 mon sticky");
        chk("R5", "mon sticky", mon, 1);
        srd = 1; step("R10");

        // R6 / R7
        trip = 1; low = 1; pd = 1; step("R6 pwrdn");
        trip = 1; low = 1; rdis = 1; step("R6 rstdis");
        chk("R6", "ignored", st, 0);
        chk("R6", "no req", req, 0);
        low = 0; step("R6");
        trip = 1; low = 1; step("R6 lvi");
        chk("R6", "lvi bit", st[4], 1);
        for (int i = 0; i < PL + 5; i++) begin low = 1; step("R7 hold"); end
        chk("R7", "held while low", req, 1);
        low = 0; step("R7 release");
        chk("R7", "released", req, 0);

        // R11 simultaneous
        srd = 1; step("R10");
        stp = 1; rd = 1; opc = 1; mapped = 0; trip = 1; low = 1; step("R11 multi");
        chk("R11", "all bits", st, 5'b10110);
        wait_quiet("R11");

        // R9 again with mon set
        rst = 1; step("R9 por2");
        chk("R9", "mon cleared", mon, 0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int a;
            rst = ($urandom % 200) == 0;
            rd = $urandom % 2; opc = $urandom % 2;
            mapped = ($urandom % 5) != 0;
            a = $urandom % 4;
            addr = (a == 0) ? VA : (a == 1) ? VA + 16'd1 : 16'($urandom);
            data = ($urandom % 2) ? 8'hFF : 8'($urandom);
            stp = ($urandom % 20) == 0; sen = $urandom % 2;
            pd = ($urandom % 3) == 0; rdis = ($urandom % 3) == 0;
            trip = ($urandom % 25) == 0;
            low = trip | (($urandom % 4) != 0 && m_hold);
            srd = ($urandom % 10) == 0;
            step("R11 random");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule